// File: doc/BRIEF.md
# Ready-Paced SPI Controller with Word FIFOs

This block is a serial peripheral controller that moves words between two 8-entry FIFOs and the four SPI wires. Software, or a neighbouring engine, pushes outgoing words into the transmit FIFO and pops incoming words from the receive FIFO. The block can act as bus master or as bus slave. The word length can be set from 1 to 16 bits, and bits go out most significant first.

As master, the block drives the clock and an active-low select. Each word starts only when the transmit FIFO holds data. A flow-control input, `spiRdy`, can be ignored, or it can be set to admit exactly one word per falling edge. A programmable period register inserts a fixed idle time, counted in serial-clock periods, between consecutive words. While that idle time runs, the select is released.

As slave, the select and clock are inputs. The falling edge of the select loads the next transmit word into the shift register. Its rising edge stores the received word into the receive FIFO. Clock polarity and phase are set to match the external master.

Top module: `spi_burst_ctrl`

## Requirements
- R1: As master, one transfer exchanges cfgWordLen+1 bits (cfgWordLen in 0..15), MSB first on sdOut and into the received word from sdIn; bits of txData above the word length are ignored and received words are zero-extended.
- R2: The clock idles at the level cfgCpol; with cfgCpha=0 data is sampled on the first (leading) clock edge of each bit, with cfgCpha=1 on the second (trailing) edge.
- R3: A master never asserts ssNOut (drives it low) while the transmit FIFO is empty.
- R4: With cfgRdyEdge=1 the master starts no word until spiRdy falls, and then starts exactly one word per falling edge; with cfgRdyEdge=0 spiRdy has no effect.
- R5: With cfgPeriod=P>0 the master releases ssNOut (high) after each word for at least 2*HALF_CYC*P and at most 2*HALF_CYC*P+2 clock cycles before the next word; with P=0 queued words follow each other with ssNOut held low.
- R6: As master, ssNOut is low for the whole of each word, and sclkOut equals cfgCpol whenever ssNOut is high; as slave, ssNOut stays high and sclkOut stays at cfgCpol.
- R7: Each FIFO holds 8 words; empty means 0 words, half means at least 4 words, full means 8 words.
- R8: A word that completes while the receive FIFO is full is discarded and sets overrun, which stays set until overrunClr is pulsed.
- R9: As slave, a falling ssNIn loads the head of the transmit FIFO (all zeros if the FIFO is empty), and a rising ssNIn pushes the received word into the receive FIFO.
- R10: As slave, sampling and shifting follow cfgCpol and cfgCpha exactly as in R2, with sclkIn as the clock.
- R11: After reset ssNOut is high, sclkOut equals cfgCpol, both FIFOs are empty and overrun is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1 selects master, 0 selects slave |
| cfgCpol | input | 1 | Idle level of the serial clock |
| cfgCpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfgRdyEdge | input | 1 | 0: spiRdy ignored, 1: one word per spiRdy falling edge |
| cfgWordLen | input | 4 | Word length minus one |
| cfgPeriod | input | 8 | Inter-word idle time in serial-clock periods |
| txPush | input | 1 | Write txData into the transmit FIFO |
| txData | input | 16 | Word to transmit |
| rxPop | input | 1 | Remove the head of the receive FIFO |
| rxData | output | 16 | Head of the receive FIFO |
| txEmpty | output | 1 | Transmit FIFO empty |
| txFull | output | 1 | Transmit FIFO full |
| txHalf | output | 1 | Transmit FIFO at least half full |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxFull | output | 1 | Receive FIFO full |
| rxHalf | output | 1 | Receive FIFO at least half full |
| overrun | output | 1 | Sticky receive overrun flag |
| overrunClr | input | 1 | Clears the overrun flag |
| spiRdy | input | 1 | Flow-control input for master pacing |
| sclkOut | output | 1 | Serial clock driven as master |
| ssNOut | output | 1 | Active-low select driven as master |
| sdOut | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sclkIn | input | 1 | Serial clock received as slave |
| ssNIn | input | 1 | Active-low select received as slave |
| sdIn | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
A wrong bit counter or shift alignment shows up at the ports when the word completes: the captured sdOut word or the popped rxData is off by a shift, or is truncated. A pacing fault in the sequencer shows as an ssNOut fall with an empty transmit FIFO, or as a shortened idle gap. Either shows at the very next select edge, well before the FIFO contents are read. A FIFO pointer or flag fault shows at the latest after eight pushes or pops, through inconsistent empty, half and full flags or through a lost or extra word.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef struct packed {
    logic load;
    logic loadZero;
    logic sampleEdge;
    logic driveEdge;
    logic push;
  } spiStrobe_t;

  typedef enum logic [2:0] {MS_IDLE, MS_SETUP, MS_XFER, MS_HOLD, MS_WAIT} mstState_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              half
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [AW:0]       count;
  logic              doPush, doPop;

  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign half  = (count >= (AW+1)'(DEPTH/2));
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [LW-1:0]     cfgWordLen,
  input  logic [DATA_W-1:0] txHead,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxValid
);
  logic [DATA_W-1:0] txSh, rxSh, lenMask;
  logic              gotSample;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (i <= int'(cfgWordLen));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh      <= '0;
      rxSh      <= '0;
      gotSample <= 1'b0;
    end else if (strobe.load) begin
      txSh      <= strobe.loadZero ? '0 : txHead;
      rxSh      <= '0;
      gotSample <= 1'b0;
    end else begin
      if (strobe.sampleEdge) begin
        rxSh      <= {rxSh[DATA_W-2:0], sdIn};
        gotSample <= 1'b1;
      end
      if (strobe.driveEdge && gotSample) txSh <= txSh << 1;
    end
  end

  assign sdOut   = txSh[cfgWordLen];
  assign rxWord  = rxSh & lenMask;
  assign rxValid = strobe.push;
endmodule

// File: rtl/spi_burst_ctl.sv
module spi_burst_ctl
  import spi_burst_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int PERIOD_W = 8,
  parameter int LW       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic                cfgCpol,
  input  logic                cfgCpha,
  input  logic                cfgRdyEdge,
  input  logic [LW-1:0]       cfgWordLen,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                spiRdy,
  input  logic                sclkIn,
  input  logic                ssNIn,
  input  logic                txEmpty,
  input  logic                rxFull,
  input  logic                overrunClr,
  output spiStrobe_t          strobe,
  output logic                txPop,
  output logic                sclkOut,
  output logic                ssNOut,
  output logic                overrun
);
  localparam int HW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;

  mstState_t         state;
  logic [HW-1:0]     halfCnt;
  logic [LW:0]       edgeCnt;
  logic [PERIOD_W:0] waitCnt, waitLast;
  logic              sclkPh, rdyPend;
  logic [2:0]        rdySync, sclkSync, ssSync;
  logic              halfLast, canStart, mLoad, mToggle, mPush;
  logic              sFall, sRise, sEdge, sLead, sTrail, lead, trail;

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdySync  <= 3'b111;
      sclkSync <= 3'b000;
      ssSync   <= 3'b111;
    end else begin
      rdySync  <= {rdySync[1:0], spiRdy};
      sclkSync <= {sclkSync[1:0], sclkIn};
      ssSync   <= {ssSync[1:0], ssNIn};
    end
  end

  assign halfLast = (halfCnt == HW'(HALF_CYC - 1));
  assign waitLast = {cfgPeriod, 1'b0} - 1'b1;
  assign canStart = !txEmpty && (!cfgRdyEdge || rdyPend);
  assign mLoad    = cfgMaster && canStart &&
                    (state == MS_IDLE || (state == MS_HOLD && halfLast && cfgPeriod == '0));
  assign mToggle  = (state == MS_XFER) && halfLast;
  assign mPush    = (state == MS_HOLD) && halfLast;

  // slave edge detection
  assign sFall  = ssSync[2] && !ssSync[1];
  assign sRise  = !ssSync[2] && ssSync[1];
  assign sEdge  = !ssSync[1] && (sclkSync[2] != sclkSync[1]);
  assign sLead  = sEdge && (sclkSync[1] != cfgCpol);
  assign sTrail = sEdge && (sclkSync[1] == cfgCpol);

  assign lead  = cfgMaster ? (mToggle && !sclkPh) : sLead;
  assign trail = cfgMaster ? (mToggle && sclkPh)  : sTrail;

  always_comb begin
    strobe.load       = cfgMaster ? mLoad : sFall;
    strobe.loadZero   = !cfgMaster && txEmpty;
    strobe.sampleEdge = cfgCpha ? trail : lead;
    strobe.driveEdge  = cfgCpha ? lead : trail;
    strobe.push       = cfgMaster ? mPush : sRise;
  end

  assign txPop   = strobe.load && !txEmpty;
  assign sclkOut = (cfgMaster && sclkPh) ^ cfgCpol;
  assign ssNOut  = !cfgMaster || state == MS_IDLE || state == MS_WAIT;

  // master sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= MS_IDLE;
      halfCnt <= '0;
      edgeCnt <= '0;
      waitCnt <= '0;
      sclkPh  <= 1'b0;
    end else if (!cfgMaster) begin
      state   <= MS_IDLE;
      halfCnt <= '0;
      sclkPh  <= 1'b0;
    end else begin
      halfCnt <= halfLast ? '0 : halfCnt + 1'b1;
      case (state)
        MS_IDLE: begin
          halfCnt <= '0;
          if (mLoad) state <= MS_SETUP;
        end
        MS_SETUP: begin
          if (halfLast) begin
            state   <= MS_XFER;
            edgeCnt <= '0;
          end
        end
        MS_XFER: begin
          if (halfLast) begin
            sclkPh  <= !sclkPh;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == {cfgWordLen, 1'b1}) state <= MS_HOLD;
          end
        end
        MS_HOLD: begin
          if (halfLast) begin
            if (mLoad)                  state <= MS_SETUP;
            else if (cfgPeriod != '0) begin
              state   <= MS_WAIT;
              waitCnt <= '0;
            end else                    state <= MS_IDLE;
          end
        end
        MS_WAIT: begin
          if (halfLast) begin
            waitCnt <= waitCnt + 1'b1;
            if (waitCnt == waitLast) state <= MS_IDLE;
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  // ready pacing and overrun flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyPend <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (cfgRdyEdge && rdySync[2] && !rdySync[1]) rdyPend <= 1'b1;
      else if (mLoad || !cfgRdyEdge)               rdyPend <= 1'b0;
      if (strobe.push && rxFull) overrun <= 1'b1;
      else if (overrunClr)       overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int HALF_CYC   = 4,
  parameter int PERIOD_W   = 8,
  localparam int LW = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic                cfgCpol,
  input  logic                cfgCpha,
  input  logic                cfgRdyEdge,
  input  logic [LW-1:0]       cfgWordLen,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                txPush,
  input  logic [DATA_W-1:0]   txData,
  input  logic                rxPop,
  output logic [DATA_W-1:0]   rxData,
  output logic                txEmpty,
  output logic                txFull,
  output logic                txHalf,
  output logic                rxEmpty,
  output logic                rxFull,
  output logic                rxHalf,
  output logic                overrun,
  input  logic                overrunClr,
  input  logic                spiRdy,
  output logic                sclkOut,
  output logic                ssNOut,
  output logic                sdOut,
  input  logic                sclkIn,
  input  logic                ssNIn,
  input  logic                sdIn
);
  spiStrobe_t        strobe;
  logic              txPop, rxValid;
  logic [DATA_W-1:0] txHead, rxWord;

  spi_burst_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData), .pop(txPop),
    .head(txHead), .empty(txEmpty), .full(txFull), .half(txHalf));

  spi_burst_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxValid), .pushData(rxWord), .pop(rxPop),
    .head(rxData), .empty(rxEmpty), .full(rxFull), .half(rxHalf));

  spi_burst_ctl #(.HALF_CYC(HALF_CYC), .PERIOD_W(PERIOD_W), .LW(LW)) uCtl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgRdyEdge(cfgRdyEdge), .cfgWordLen(cfgWordLen), .cfgPeriod(cfgPeriod),
    .spiRdy(spiRdy), .sclkIn(sclkIn), .ssNIn(ssNIn), .txEmpty(txEmpty), .rxFull(rxFull),
    .overrunClr(overrunClr), .strobe(strobe), .txPop(txPop), .sclkOut(sclkOut),
    .ssNOut(ssNOut), .overrun(overrun));

  spi_burst_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWordLen(cfgWordLen), .txHead(txHead),
    .sdIn(sdIn), .sdOut(sdOut), .rxWord(rxWord), .rxValid(rxValid));
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
  parameter int HALF_CYC = 4,
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgMaster,
  input logic                cfgCpol,
  input logic [PERIOD_W-1:0] cfgPeriod,
  input logic                txEmpty,
  input logic                txFull,
  input logic                rxEmpty,
  input logic                rxFull,
  input logic                rxHalf,
  input logic                overrun,
  input logic                overrunClr,
  input logic                sclkOut,
  input logic                ssNOut
);
  logic [15:0]         hiCnt;
  logic                seenWord;
  logic [PERIOD_W-1:0] prevPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt      <= '0;
      seenWord   <= 1'b0;
      prevPeriod <= '0;
    end else begin
      prevPeriod <= cfgPeriod;
      if (ssNOut) hiCnt <= (hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 1'b1;
      else        hiCnt <= '0;
      if (!cfgMaster || cfgPeriod != prevPeriod) seenWord <= 1'b0;
      else if (!ssNOut)                          seenWord <= 1'b1;
    end
  end

  assert_idle_clock_R6: assert property (@(posedge clk) disable iff (!rstN)
    ssNOut |-> (sclkOut == cfgCpol));

  assert_no_empty_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $fell(ssNOut)) |-> $past(!txEmpty));

  assert_gap_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && cfgPeriod != '0 && seenWord && $fell(ssNOut)) |->
      (int'(hiCnt) >= 2 * HALF_CYC * int'(cfgPeriod)));

  assert_tx_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> !txEmpty);

  assert_rx_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> (rxHalf && !rxEmpty));

  assert_sticky_overrun_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun);
endmodule

bind spi_burst_ctrl spi_burst_chk #(.HALF_CYC(HALF_CYC), .PERIOD_W(PERIOD_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgCpol(cfgCpol), .cfgPeriod(cfgPeriod),
  .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull), .rxHalf(rxHalf),
  .overrun(overrun), .overrunClr(overrunClr), .sclkOut(sclkOut), .ssNOut(ssNOut));

// File: tb/tb_spi_burst_ctrl.sv
module tb_spi_burst_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgCpol = 1'b0, cfgCpha = 1'b0, cfgRdyEdge = 1'b0;
  logic [3:0] cfgWordLen = 4'd15;
  logic [7:0] cfgPeriod = 8'd0;
  logic txPush = 0, rxPop = 0, overrunClr = 0, spiRdy = 1;
  logic [15:0] txData = '0, rxData;
  logic txEmpty, txFull, txHalf, rxEmpty, rxFull, rxHalf, overrun;
  logic sclkOut, ssNOut, sdOut, sdIn;
  logic sclkInS = 0, ssNInS = 1, sdInS = 0;

  int total = 0, bad = 0, cycles = 0;

  // bench slave model state
  logic [15:0] mSh = '0, slvWord = '0, capt = '0;
  logic [15:0] capArr [16];
  int capN = 0, sCnt = 0, ssFalls = 0, hiRun = 0, gapLast = 0;
  logic gotS = 0, prevSs = 1, prevSclk = 0;

  always #10 clk = ~clk;

  assign sdIn = cfgMaster ? mSh[cfgWordLen] : sdInS;

  spi_burst_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgRdyEdge(cfgRdyEdge), .cfgWordLen(cfgWordLen), .cfgPeriod(cfgPeriod),
    .txPush(txPush), .txData(txData), .rxPop(rxPop), .rxData(rxData),
    .txEmpty(txEmpty), .txFull(txFull), .txHalf(txHalf), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .rxHalf(rxHalf), .overrun(overrun), .overrunClr(overrunClr),
    .spiRdy(spiRdy), .sclkOut(sclkOut), .ssNOut(ssNOut), .sdOut(sdOut),
    .sclkIn(sclkInS), .ssNIn(ssNInS), .sdIn(sdIn));

  function automatic logic [15:0] msk(input logic [3:0] wl);
    for (int i = 0; i < 16; i++) msk[i] = (i <= int'(wl));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // serial slave model and select monitor for master mode
  always @(negedge clk) begin
    if (!rstN) begin
      prevSs = 1; prevSclk = sclkOut; hiRun = 0;
    end else begin
      if (ssNOut) hiRun++;
      if (prevSs && !ssNOut) begin
        ssFalls++; gapLast = hiRun; mSh = slvWord; gotS = 0; sCnt = 0; capt = '0;
      end
      if (!ssNOut) hiRun = 0;
      if (cfgMaster && !ssNOut && sclkOut != prevSclk) begin
        if ((sclkOut != cfgCpol) ^ cfgCpha) begin
          capt = {capt[14:0], sdOut}; gotS = 1; sCnt++;
          if (sCnt == int'(cfgWordLen) + 1) begin
            if (capN < 16) capArr[capN] = capt & msk(cfgWordLen);
            capN++; sCnt = 0; gotS = 0;
          end
        end else if (gotS) mSh = mSh << 1;
      end
      prevSs = ssNOut; prevSclk = sclkOut;
    end
  end

  task automatic pushTx(input logic [15:0] d);
    @(negedge clk); txData = d; txPush = 1;
    @(negedge clk); txPush = 0;
  endtask

  task automatic popRx(output logic [15:0] d);
    @(negedge clk); d = rxData; rxPop = 1;
    @(negedge clk); rxPop = 0;
  endtask

  task automatic waitRx(input string req);
    int n = 0;
    while (rxEmpty && n < 3000) begin @(negedge clk); n++; end
    chk(!rxEmpty, req, 32'(rxEmpty), 0);
  endtask

  task automatic waitIdle();
    int n = 0;
    while ((!ssNOut || !txEmpty) && n < 6000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
  endtask

  task automatic slaveXfer(input logic [15:0] outW, input int n, output logic [15:0] got);
    got = '0;
    @(negedge clk); ssNInS = 0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (!cfgCpha) begin
        sdInS = outW[i]; repeat (8) @(negedge clk);
        got = {got[14:0], sdOut}; sclkInS = ~cfgCpol; repeat (8) @(negedge clk);
        sclkInS = cfgCpol;
      end else begin
        sclkInS = ~cfgCpol; sdInS = outW[i]; repeat (8) @(negedge clk);
        got = {got[14:0], sdOut}; sclkInS = cfgCpol; repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk); ssNInS = 1;
    repeat (8) @(negedge clk);
  endtask

  // {wordLen-1, cpol, cpha, tx word, word returned by the far end}
  localparam logic [37:0] VEC [6] = '{
    {4'd15, 1'b0, 1'b0, 16'hA5C3, 16'h3C5A},
    {4'd7,  1'b1, 1'b0, 16'hFFB4, 16'h004D},
    {4'd11, 1'b0, 1'b1, 16'h0ABC, 16'hF0F0},
    {4'd15, 1'b1, 1'b1, 16'h8001, 16'h7FFE},
    {4'd0,  1'b0, 1'b0, 16'h0001, 16'h0000},
    {4'd4,  1'b1, 1'b1, 16'h0015, 16'h000A}
  };

  initial begin
    logic [15:0] got, txw;
    int f0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk(ssNOut == 1 && sclkOut == cfgCpol, "R11 select/clock idle", {ssNOut, sclkOut}, 32'h2);
    chk(txEmpty && rxEmpty && !txFull && !rxFull && !overrun, "R11 fifo/overrun",
        {txEmpty, rxEmpty, txFull, rxFull, overrun}, 32'h18);

    // R1/R2: vector table, master mode, one word each
    foreach (VEC[k]) begin
      cfgWordLen = VEC[k][37:34]; cfgCpol = VEC[k][33]; cfgCpha = VEC[k][32];
      slvWord = VEC[k][15:0]; capN = 0;
      repeat (6) @(negedge clk);
      pushTx(VEC[k][31:16]);
      waitRx("R1 word completes");
      popRx(got);
      chk(got == (VEC[k][15:0] & msk(cfgWordLen)), "R1 received word", got, VEC[k][15:0] & msk(cfgWordLen));
      chk(capN == 1 && capArr[0] == (VEC[k][31:16] & msk(cfgWordLen)), "R2 transmitted word MSB first",
          capArr[0], VEC[k][31:16] & msk(cfgWordLen));
      waitIdle();
      chk(sclkOut == cfgCpol && ssNOut, "R6 idle clock level", sclkOut, cfgCpol);
    end

    // R3: empty transmit FIFO starts nothing
    cfgWordLen = 4'd15; cfgCpol = 0; cfgCpha = 0; slvWord = 16'h1234;
    f0 = ssFalls;
    repeat (60) @(negedge clk);
    chk(ssFalls == f0 && ssNOut, "R3 no start when empty", ssFalls - f0, 0);

    // R7 flags and R4 edge pacing
    cfgRdyEdge = 1;
    for (int i = 0; i < 4; i++) pushTx(16'h1100 + 16'(i));
    chk(txHalf && !txFull && !txEmpty, "R7 half at four", {txHalf, txFull, txEmpty}, 32'h4);
    for (int i = 4; i < 8; i++) pushTx(16'h1100 + 16'(i));
    chk(txFull && txHalf, "R7 full at eight", {txFull, txHalf}, 32'h3);
    repeat (150) @(negedge clk);
    chk(rxEmpty && ssFalls == f0, "R4 no word without ready edge", ssFalls - f0, 0);
    capN = 0;
    spiRdy = 0; repeat (4) @(negedge clk); spiRdy = 1;
    waitRx("R4 word after ready edge");
    repeat (300) @(negedge clk);
    chk(ssFalls == f0 + 1, "R4 exactly one word per edge", ssFalls - f0, 1);
    popRx(got);
    chk(rxEmpty && got == 16'h1234, "R4 one received word", got, 16'h1234);
    chk(capArr[0] == 16'h1100, "R4 first queued word sent", capArr[0], 16'h1100);

    // R5 period zero: remaining seven words back to back
    f0 = ssFalls; capN = 0;
    cfgRdyEdge = 0;
    waitIdle();
    chk(ssFalls == f0 + 1, "R5 select held across queued words", ssFalls - f0, 1);
    chk(capN == 7 && capArr[6] == 16'h1107 && capArr[0] == 16'h1101, "R5 queued order",
        capArr[6], 16'h1107);

    // R8 overrun: receive FIFO holds 7, two more words arrive
    pushTx(16'h2222); pushTx(16'h3333);
    waitIdle();
    chk(rxFull && overrun, "R8 overrun set on full", {rxFull, overrun}, 32'h3);
    for (int i = 0; i < 8; i++) popRx(got);
    chk(rxEmpty, "R8 ninth word discarded", 32'(rxEmpty), 1);
    repeat (20) @(negedge clk);
    chk(overrun, "R8 flag sticky", 32'(overrun), 1);
    @(negedge clk); overrunClr = 1; @(negedge clk); overrunClr = 0;
    chk(!overrun, "R8 flag cleared", 32'(overrun), 0);

    // R5 period two: idle gap between words
    cfgPeriod = 8'd2;
    repeat (60) @(negedge clk);
    pushTx(16'h4444); pushTx(16'h5555);
    waitIdle();
    chk(gapLast >= 16 && gapLast <= 18, "R5 inter-word gap", gapLast, 17);
    popRx(got); popRx(got);
    cfgPeriod = 8'd0;

    // R9/R10 slave mode
    cfgMaster = 0; cfgCpol = 0; cfgCpha = 0; cfgWordLen = 4'd15; sclkInS = 0;
    repeat (10) @(negedge clk);
    chk(ssNOut && sclkOut == cfgCpol, "R6 slave leaves master pins idle", {ssNOut, sclkOut}, 32'h2);
    pushTx(16'hC35A);
    slaveXfer(16'h5AA5, 16, got);
    chk(got == 16'hC35A, "R9 slave transmits loaded word", got, 16'hC35A);
    popRx(got);
    chk(got == 16'h5AA5, "R9 slave stores word on select rise", got, 16'h5AA5);

    cfgCpol = 1; cfgCpha = 1; cfgWordLen = 4'd7; sclkInS = 1;
    repeat (10) @(negedge clk);
    pushTx(16'h0096);
    slaveXfer(16'h003C, 8, got);
    chk(got[7:0] == 8'h96, "R10 slave cpol1 cpha1 transmit", got[7:0], 8'h96);
    popRx(got);
    chk(got == 16'h003C, "R10 slave cpol1 cpha1 receive", got, 16'h003C);

    txw = 16'h00FF;
    slaveXfer(txw, 8, got);
    chk(got[7:0] == 8'h00, "R9 slave sends zeros when empty", got[7:0], 0);
    popRx(got);
    chk(got == 16'h00FF, "R9 slave receive with empty tx", got, 16'h00FF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule